// File: doc/BRIEF.md
# Power Domain Power-Up Sequencer

This block takes one switchable power domain out of power-down in a safe, fixed order. A one-cycle start pulse carries the index of the domain. The sequencer first puts the domain's peripheral logic into reset. It then issues a power-switch toggle, but only when the domain is not already powered. Next it turns on the domain clock and waits for the clock-ready input. After a settle interval it releases the isolation clamp. After a second settle interval it takes the peripheral reset away and pulses done.

When something fails, the steps already taken are undone in the opposite order, and the sequencer ends with an error pulse and a code. There are two failure cases. If the clock never reports ready, the clock request is dropped and the domain is switched off again. If the clamp release is refused, the clock is disabled first and then the power is switched off. In both cases the peripheral reset stays asserted.

An index outside the configured domain count is refused and no domain output moves. Settle intervals are counted in clock cycles: a microsecond count multiplied by a cycles-per-microsecond parameter. Only one domain is handled at a time, and any start pulse that arrives while a sequence is running is dropped.

Top module: `pwrup_seq`

## Requirements
- R1: After reset, `prst_o`, `clk_en_o`, `pwr_toggle_o`, `unclamp_o`, `dom_o`, `busy_o`, `done_o`, `err_o` and `err_code_o` are all zero.
- R2: On an accepted start, the domain's bit in `prst_o` is set before any power toggle or clock enable for that domain, one cycle after the start is sampled.
- R3: One cycle after the reset step, `pwr_toggle_o` pulses for one cycle only if the domain's bit of `pwr_status_i` reads 0. If that bit reads 1, no toggle is issued.
- R4: The domain's `clk_en_o` bit rises in the cycle after the power step. With `clk_rdy_i` already high, `unclamp_o` pulses exactly SETTLE+1 cycles after that rise, where SETTLE = SETTLE_US*CYC_PER_US.
- R5: `unclamp_o` is only ever high while the `clk_en_o` and `prst_o` bits of the domain in `dom_o` are both high.
- R6: The domain's `prst_o` bit clears together with a one-cycle `done_o` pulse, SETTLE+1 cycles after the unclamp pulse. `clk_en_o` stays high afterwards.
- R7: If `clk_rdy_i` is not seen within CLK_TMO cycles of the clock-enable rise, the following happens. The clock-enable bit is high for exactly CLK_TMO cycles and then drops. The domain is toggled back off if `pwr_status_i` shows it powered. `err_o` pulses with `err_code_o` = 2. `prst_o` stays set.
- R8: If `clamp_err_i` is high during the unclamp cycle, the following happens in order. The clock enable drops. One cycle later the domain is toggled off if it reads powered. Then `err_o` pulses with `err_code_o` = 3, and `prst_o` stays set.
- R9: A start with `dom_i` >= NUM_DOMAINS gives `err_o` with `err_code_o` = 1 one cycle after the start is sampled. In that case `prst_o`, `clk_en_o` and `dom_o` do not change, and no toggle or unclamp pulse occurs.
- R10: `busy_o` is high from the cycle after an accepted start through the `done_o`/`err_o` cycle and low the cycle after. A start pulse while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to power up a domain |
| dom_i | input | IDX_W | Index of the domain to bring up |
| pwr_status_i | input | NUM_DOMAINS | Current powered state of each domain |
| clk_rdy_i | input | 1 | Domain clock reports running |
| clamp_err_i | input | 1 | Clamp release refused, sampled in the unclamp cycle |
| prst_o | output | NUM_DOMAINS | Peripheral reset hold per domain |
| clk_en_o | output | NUM_DOMAINS | Clock enable per domain |
| pwr_toggle_o | output | 1 | One-cycle power switch toggle for `dom_o` |
| unclamp_o | output | 1 | One-cycle clamp release for `dom_o` |
| dom_o | output | IDX_W | Domain currently or last handled |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | One-cycle failure pulse |
| err_code_o | output | 2 | 0 none, 1 bad index, 2 clock timeout, 3 clamp failure |

## Verification
The bound checker watches several properties on every cycle. It checks that a toggle only happens while the domain's reset is held. It checks that the clamp is only released with the clock on and the reset held. It checks that done comes with the reset released, the clock on, and at least SETTLE cycles after the unclamp. It also checks that done and error never coincide, that busy is held until one of them, and that a failed sequence leaves reset held and the clock off. The bench scenarios are the only place that shows the exact cycle offsets of the steps, and the conditional toggle depending on the power status. They also cover the timeout length, the toggle count during unwinding, the bad-index case leaving the outputs untouched, and the dropping of a start pulse that arrives mid-sequence.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RST,
        S_PWR,
        S_CLK,
        S_WAIT_CLK,
        S_UNCLAMP,
        S_WAIT_CLAMP,
        S_DONE,
        S_UNCLK,
        S_UNPWR,
        S_FAIL
    } seq_state_e;

    localparam logic [1:0] ERR_NONE  = 2'd0;
    localparam logic [1:0] ERR_RANGE = 2'd1;
    localparam logic [1:0] ERR_CLK   = 2'd2;
    localparam logic [1:0] ERR_CLAMP = 2'd3;

endpackage

// File: rtl/pwrup_dom_dec.sv
module pwrup_dom_dec #(
    parameter int NUM_DOMAINS = 6,
    parameter int IDX_W       = 4
) (
    input  logic [IDX_W-1:0]       idx_i,
    output logic [NUM_DOMAINS-1:0] onehot_o,
    output logic                   in_range_o
);

    for (genvar g = 0; g < NUM_DOMAINS; g++) begin : g_dec
        assign onehot_o[g] = (idx_i == IDX_W'(g));
    end

    assign in_range_o = |onehot_o;

endmodule

// File: rtl/pwrup_tick_cnt.sv
module pwrup_tick_cnt #(
    parameter int SETTLE = 2500,
    parameter int TMO    = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic settle_hit_o,
    output logic tmo_hit_o
);

    localparam int CNT_MAX = (SETTLE > TMO) ? SETTLE : TMO;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (cnt_q != CNT_W'(CNT_MAX)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign settle_hit_o = (cnt_q == CNT_W'(SETTLE - 1));
    assign tmo_hit_o    = (cnt_q == CNT_W'(TMO - 1));

endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
    import pwrup_pkg::*;
#(
    parameter int NUM_DOMAINS = 6,
    parameter int CYC_PER_US  = 250,
    parameter int SETTLE_US   = 10,
    parameter int CLK_TMO     = 1000,
    parameter int IDX_W       = $clog2(NUM_DOMAINS) + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [IDX_W-1:0]       dom_i,
    input  logic [NUM_DOMAINS-1:0] pwr_status_i,
    input  logic                   clk_rdy_i,
    input  logic                   clamp_err_i,
    output logic [NUM_DOMAINS-1:0] prst_o,
    output logic [NUM_DOMAINS-1:0] clk_en_o,
    output logic                   pwr_toggle_o,
    output logic                   unclamp_o,
    output logic [IDX_W-1:0]       dom_o,
    output logic                   busy_o,
    output logic                   done_o,
    output logic                   err_o,
    output logic [1:0]             err_code_o
);

    localparam int SETTLE = SETTLE_US * CYC_PER_US;

    typedef struct packed {
        seq_state_e             st;
        logic [IDX_W-1:0]       dom;
        logic [NUM_DOMAINS-1:0] prst;
        logic [NUM_DOMAINS-1:0] clk_en;
        logic                   toggle;
        logic                   unclamp;
        logic                   done;
        logic                   err;
        logic [1:0]             code;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [NUM_DOMAINS-1:0] oh_in, oh_cur;
    logic                   in_range, cur_valid;
    logic                   cur_powered;
    logic                   settle_hit, tmo_hit;
    logic                   cnt_clr;

    pwrup_dom_dec #(
        .NUM_DOMAINS(NUM_DOMAINS),
        .IDX_W      (IDX_W)
    ) i_dec_in (
        .idx_i     (dom_i),
        .onehot_o  (oh_in),
        .in_range_o(in_range)
    );

    pwrup_dom_dec #(
        .NUM_DOMAINS(NUM_DOMAINS),
        .IDX_W      (IDX_W)
    ) i_dec_cur (
        .idx_i     (r_q.dom),
        .onehot_o  (oh_cur),
        .in_range_o(cur_valid)
    );

    assign cur_powered = cur_valid && |(pwr_status_i & oh_cur);
    assign cnt_clr     = (r_d.st != r_q.st);

    pwrup_tick_cnt #(
        .SETTLE(SETTLE),
        .TMO   (CLK_TMO)
    ) i_tick (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (cnt_clr),
        .settle_hit_o(settle_hit),
        .tmo_hit_o   (tmo_hit)
    );

    always_comb begin
        r_d         = r_q;
        r_d.toggle  = 1'b0;
        r_d.unclamp = 1'b0;
        r_d.done    = 1'b0;
        r_d.err     = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (start_i) begin
                    if (in_range) begin
                        r_d.dom  = dom_i;
                        r_d.prst = r_q.prst | oh_in;
                        r_d.code = ERR_NONE;
                        r_d.st   = S_RST;
                    end else begin
                        r_d.code = ERR_RANGE;
                        r_d.err  = 1'b1;
                        r_d.st   = S_FAIL;
                    end
                end
            end
            S_RST: begin
                r_d.toggle = !cur_powered;
                r_d.st     = S_PWR;
            end
            S_PWR: begin
                r_d.clk_en = r_q.clk_en | oh_cur;
                r_d.st     = S_CLK;
            end
            S_CLK: begin
                if (clk_rdy_i) begin
                    r_d.st = S_WAIT_CLK;
                end else if (tmo_hit) begin
                    r_d.clk_en = r_q.clk_en & ~oh_cur;
                    r_d.toggle = cur_powered;
                    r_d.code   = ERR_CLK;
                    r_d.st     = S_UNPWR;
                end
            end
            S_WAIT_CLK: begin
                if (settle_hit) begin
                    r_d.unclamp = 1'b1;
                    r_d.st      = S_UNCLAMP;
                end
            end
            S_UNCLAMP: begin
                if (clamp_err_i) begin
                    r_d.clk_en = r_q.clk_en & ~oh_cur;
                    r_d.code   = ERR_CLAMP;
                    r_d.st     = S_UNCLK;
                end else begin
                    r_d.st = S_WAIT_CLAMP;
                end
            end
            S_WAIT_CLAMP: begin
                if (settle_hit) begin
                    r_d.prst = r_q.prst & ~oh_cur;
                    r_d.done = 1'b1;
                    r_d.st   = S_DONE;
                end
            end
            S_UNCLK: begin
                r_d.toggle = cur_powered;
                r_d.st     = S_UNPWR;
            end
            S_UNPWR: begin
                r_d.err = 1'b1;
                r_d.st  = S_FAIL;
            end
            S_DONE:  r_d.st = S_IDLE;
            S_FAIL:  r_d.st = S_IDLE;
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign prst_o       = r_q.prst;
    assign clk_en_o     = r_q.clk_en;
    assign pwr_toggle_o = r_q.toggle;
    assign unclamp_o    = r_q.unclamp;
    assign dom_o        = r_q.dom;
    assign busy_o       = (r_q.st != S_IDLE);
    assign done_o       = r_q.done;
    assign err_o        = r_q.err;
    assign err_code_o   = r_q.code;

endmodule

// File: rtl/pwrup_seq_chk.sv
module pwrup_seq_chk #(
    parameter int NUM_DOMAINS = 6,
    parameter int IDX_W       = 4,
    parameter int SETTLE      = 40
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_DOMAINS-1:0] prst_o,
    input logic [NUM_DOMAINS-1:0] clk_en_o,
    input logic                   pwr_toggle_o,
    input logic                   unclamp_o,
    input logic [IDX_W-1:0]       dom_o,
    input logic                   busy_o,
    input logic                   done_o,
    input logic                   err_o,
    input logic [1:0]             err_code_o
);

    logic [31:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (unclamp_o) begin
            gap_q <= 32'd1;
        end else if (gap_q != '1) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    AST_TOGGLE_UNDER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_toggle_o |-> prst_o[dom_o]); // R2

    AST_UNCLAMP_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        unclamp_o |-> (clk_en_o[dom_o] && prst_o[dom_o])); // R5

    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!prst_o[dom_o] && clk_en_o[dom_o])); // R6

    AST_DONE_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (gap_q >= 32'(SETTLE))); // R6

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o)); // R10

    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && !err_o) |=> busy_o); // R10

    AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || err_o) |=> !busy_o); // R10

    AST_FAIL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && err_code_o != 2'd1) |-> (prst_o[dom_o] && !clk_en_o[dom_o])); // R7

endmodule

bind pwrup_seq pwrup_seq_chk #(
    .NUM_DOMAINS(NUM_DOMAINS),
    .IDX_W      (IDX_W),
    .SETTLE     (SETTLE)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .prst_o      (prst_o),
    .clk_en_o    (clk_en_o),
    .pwr_toggle_o(pwr_toggle_o),
    .unclamp_o   (unclamp_o),
    .dom_o       (dom_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .err_code_o  (err_code_o)
);

// File: tb/test_pwrup_seq.sv
`timescale 1ns/1ps
module test_pwrup_seq;

    localparam int N      = 6;
    localparam int CPU    = 4;
    localparam int SUS    = 10;
    localparam int TMO    = 16;
    localparam int IW     = $clog2(N) + 1;
    localparam int SETTLE = SUS * CPU;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [IW-1:0] dom = '0;
    logic [N-1:0]  stat;
    logic          clk_rdy = 1'b1;
    logic          clamp_err = 1'b0;
    logic [N-1:0]  prst, clk_en;
    logic          tgl, unc, busy, done, err;
    logic [IW-1:0] dom_o;
    logic [1:0]    code;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int t_prst, t_tgl, n_tgl, t_clk, n_clk_hi, t_unc, n_unc, t_end;
    bit unc_ok, end_done, end_prst, end_clk, busy_gap, busy_after;
    logic [1:0] end_code;

    always #2 clk = ~clk;

    pwrup_seq #(
        .NUM_DOMAINS(N),
        .CYC_PER_US (CPU),
        .SETTLE_US  (SUS),
        .CLK_TMO    (TMO)
    ) i_pwrup_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .dom_i       (dom),
        .pwr_status_i(stat),
        .clk_rdy_i   (clk_rdy),
        .clamp_err_i (clamp_err),
        .prst_o      (prst),
        .clk_en_o    (clk_en),
        .pwr_toggle_o(tgl),
        .unclamp_o   (unc),
        .dom_o       (dom_o),
        .busy_o      (busy),
        .done_o      (done),
        .err_o       (err),
        .err_code_o  (code)
    );

    // power switch model: domain 3 starts out powered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat <= 6'b001000;
        else if (tgl) stat[dom_o] <= ~stat[dom_o];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    // drive a start for domain d, record event cycles; ign >= 0 adds a start mid-run
    task automatic run_seq(input int d, input int ign);
        t_prst = -1; t_tgl = -1; n_tgl = 0; t_clk = -1; n_clk_hi = 0;
        t_unc = -1; n_unc = 0; t_end = -1; unc_ok = 0; busy_gap = 0;
        @(negedge clk); start = 1'b1; dom = IW'(d);
        @(negedge clk); start = 1'b0;
        for (int k = 1; k < 600; k++) begin
            if (k == 5 && ign >= 0) begin start = 1'b1; dom = IW'(ign); end
            if (k == 6) start = 1'b0;
            if (d < N) begin
                if (prst[d] && t_prst < 0) t_prst = k;
                if (clk_en[d]) begin n_clk_hi++; if (t_clk < 0) t_clk = k; end
                if (unc) begin n_unc++; t_unc = k; unc_ok = clk_en[d] && prst[d]; end
            end
            if (tgl) begin n_tgl++; if (t_tgl < 0) t_tgl = k; end
            if (!busy && !done && !err) busy_gap = 1;
            if (done || err) begin
                t_end = k; end_done = done; end_code = code;
                if (d < N) begin end_prst = prst[d]; end_clk = clk_en[d]; end
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        busy_after = busy;
    endtask

    task automatic t_reset;
        chk_eq("R1 prst", int'(prst), 0);
        chk_eq("R1 clk_en", int'(clk_en), 0);
        chk_eq("R1 pulses", int'({tgl, unc, done, err, busy}), 0);
        chk_eq("R1 dom/code", int'({dom_o, code}), 0);
    endtask

    task automatic t_normal;
        clk_rdy = 1'b1; clamp_err = 1'b0;
        run_seq(0, 4);
        chk_eq("R2 reset first", t_prst, 1);
        chk(t_prst < t_tgl && t_tgl < t_clk, "R2 order", t_tgl, t_prst + 1);
        chk_eq("R3 toggle cycle", t_tgl, 2);
        chk_eq("R3 toggle count", n_tgl, 1);
        chk_eq("R4 clk_en cycle", t_clk, 3);
        chk_eq("R4 unclamp gap", t_unc - t_clk, SETTLE + 1);
        chk_eq("R5 unclamp qual", int'(unc_ok), 1);
        chk_eq("R6 done gap", t_end - t_unc, SETTLE + 1);
        chk_eq("R6 done", int'(end_done), 1);
        chk_eq("R6 reset released", int'(end_prst), 0);
        chk_eq("R6 clock kept", int'(clk_en[0]), 1);
        chk_eq("R6 powered", int'(stat[0]), 1);
        chk_eq("R10 busy held", int'(busy_gap), 0);
        chk_eq("R10 busy low after", int'(busy_after), 0);
        chk_eq("R10 ignored start prst", int'(prst[4]), 0);
        chk_eq("R10 ignored start dom", int'(dom_o), 0);
    endtask

    task automatic t_prepowered;
        clk_rdy = 1'b1; clamp_err = 1'b0;
        run_seq(3, -1);
        chk_eq("R3 no toggle when powered", n_tgl, 0);
        chk_eq("R6 done prepowered", int'(end_done), 1);
        chk_eq("R6 still powered", int'(stat[3]), 1);
    endtask

    task automatic t_clk_timeout;
        clk_rdy = 1'b0; clamp_err = 1'b0;
        run_seq(1, -1);
        clk_rdy = 1'b1;
        chk_eq("R7 err code", int'(end_code), 2);
        chk_eq("R7 err pulse", int'(end_done), 0);
        chk_eq("R7 clk_en high cycles", n_clk_hi, TMO);
        chk_eq("R7 toggles", n_tgl, 2);
        chk_eq("R7 powered off", int'(stat[1]), 0);
        chk_eq("R7 reset held", int'(end_prst), 1);
        chk_eq("R7 clock off", int'(end_clk), 0);
        chk_eq("R7 no unclamp", n_unc, 0);
    endtask

    task automatic t_clamp_fail;
        clk_rdy = 1'b1; clamp_err = 1'b1;
        run_seq(2, -1);
        clamp_err = 1'b0;
        chk_eq("R8 err code", int'(end_code), 3);
        chk_eq("R8 unclamp seen", n_unc, 1);
        chk_eq("R8 toggles", n_tgl, 2);
        chk_eq("R8 powered off", int'(stat[2]), 0);
        chk_eq("R8 reset held", int'(end_prst), 1);
        chk_eq("R8 clock off", int'(end_clk), 0);
        chk_eq("R8 err after unclamp", t_end - t_unc, 3);
    endtask

    task automatic t_range;
        logic [N-1:0]  prst_b, clk_b;
        logic [IW-1:0] dom_b;
        prst_b = prst; clk_b = clk_en; dom_b = dom_o;
        run_seq(7, -1);
        chk_eq("R9 err code", int'(end_code), 1);
        chk_eq("R9 err cycle", t_end, 1);
        chk_eq("R9 prst unchanged", int'(prst), int'(prst_b));
        chk_eq("R9 clk_en unchanged", int'(clk_en), int'(clk_b));
        chk_eq("R9 dom unchanged", int'(dom_o), int'(dom_b));
        chk_eq("R9 no toggle/unclamp", n_tgl + n_unc, 0);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_normal();
        t_prepowered();
        t_clk_timeout();
        t_clamp_fail();
        t_range();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule